// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a serial non-volatile byte store with 128 locations of 8 bits. The host uses four pins: chip select, serial clock, serial data in and serial data out. The block samples the pins with its own system clock. It finds rising serial-clock edges and chip-select falls through synchronisers and edge detection. It then collects a start bit, a two-bit operation code, a seven-bit address and, for the writing operations, a data byte.

Reads return a stream of bytes. The first byte is the addressed one, and the address steps up by one for each following byte while chip select stays high. Every byte is preceded by a zero bit. All modifying operations are gated by an enable latch. When chip select falls after a valid modifying instruction, a timed program cycle begins and runs on the system clock alone. While that cycle runs, the data-out pin reports busy when chip select is raised. It reports ready once the cycle has finished.

The byte store is a register file with one synchronous read port and one write port. A whole-array operation sweeps through every address during the program cycle.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset the enable latch is clear, so a whole-array erase sent before any enable instruction starts no program cycle.
- R2: Zero bits clocked in while waiting for an instruction are skipped. An instruction begins with the first 1 sampled on a rising serial-clock edge. Its layout is start bit 1, then opcode MSB first, then address MSB first, then any data byte MSB first.
- R3: Opcode 10 is a read. After the last address bit, data-out gives a 0 dummy bit and then the 8 data bits MSB first. Data-out changes after each rising serial-clock edge.
- R4: During a read, the address increases by one after each byte. Another dummy 0 and the next byte follow without a new address. The address wraps from 127 to 0 while chip select stays high.
- R5: A read returns stored data whether the enable latch is set or clear.
- R6: Opcode 00 selects a special operation through address bits [6:5]. Value 11 sets the enable latch, 00 clears it, 10 is erase-all and 01 is write-all. The latch keeps its value until changed or reset.
- R7: With the enable latch clear, write, erase, erase-all and write-all leave the array unchanged and give no busy indication.
- R8: Opcode 01 is a write, and its program cycle starts on the chip-select fall. The stored byte then equals the data byte, whatever it held before, so no separate erase is needed first.
- R9: Opcode 11 is an erase, which sets the addressed byte to 8'hFF.
- R10: Erase-all sets every byte to 8'hFF. Write-all stores its data byte in every location.
- R11: While a program cycle runs and chip select is high, data-out is driven low. It is driven high once PROG_CYCLES system-clock cycles have passed since the cycle began.
- R12: Serial traffic during a program cycle is ignored.
- R13: Data-out is not driven (enable low) whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data / ready status to the host |
| sdo_en_o | output | 1 | Drive enable for sdo_o; low means high impedance |

## Verification
The bench writes a table of bytes and reads each one back. Some bytes flip bits in both directions, so a design that only cleared or only set bits would return the wrong value. A sequential read that crosses address 127 shows whether the address wraps to 0, and each dummy bit is checked as zero. A design that left out or moved the dummy bit would shift every byte by one position. The program-cycle length is measured on the busy-to-ready change, and serial traffic is sent during busy to catch a design that accepts it. Enable-latch gating is checked both right after reset and after a disable instruction; a design that ignored the latch would overwrite data and show busy.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_ARM, ST_PROG, ST_STAT, ST_SKIP
  } nvm_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic cs_lvl,
  output logic cs_fall,
  output logic sclk_rise,
  output logic din_lvl
);
  logic [2:0] stg [STAGES];
  logic       cs_prev, sclk_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= {cs_i, sclk_i, din_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= stg[STAGES-1][2];
      sclk_prev <= stg[STAGES-1][1];
    end
  end

  assign cs_lvl    = stg[STAGES-1][2];
  assign din_lvl   = stg[STAGES-1][0];
  assign cs_fall   = cs_prev & ~cs_lvl;
  assign sclk_rise = ~sclk_prev & stg[STAGES-1][1];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int PROG_CYCLES = 4000,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              bulk,
  output logic              done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (go) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (cnt == LAST_C) running <= 1'b0;
      else               cnt     <= cnt + 1'b1;
    end
  end

  assign done   = running && (cnt == LAST_C);
  assign wr_en  = running && (bulk ? (cnt < DEPTH_C) : (cnt == '0));
  assign wr_idx = cnt[ADDR_W-1:0];

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt <= LAST_C));
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  localparam int CMD_BITS = 2 + ADDR_W;
  localparam int CNT_W    = $clog2(CMD_BITS + DATA_W + 1);
  localparam int RB_W     = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [RB_W-1:0]  RB_LAST   = RB_W'(DATA_W);

  logic cs_lvl, cs_fall, sclk_rise, din_lvl;

  nvm_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sclk_i(sclk_i), .din_i(din_i),
    .cs_lvl(cs_lvl), .cs_fall(cs_fall), .sclk_rise(sclk_rise), .din_lvl(din_lvl)
  );

  nvm_state_e        state;
  logic              wel, bulk, go, rd_bit, sdo_q, sdo_en_q;
  logic [CNT_W-1:0]  bcnt;
  logic [CMD_BITS-1:0] cmd_sh, cmd_nx;
  logic [DATA_W-1:0] dat_sh, dat_nx, pat, rsh, q;
  logic [ADDR_W-1:0] tgt_addr, cur_addr, wr_idx, waddr;
  logic [RB_W-1:0]   rbit;
  logic              done, we;
  logic [1:0]        op_nx, sub_nx;

  always_comb begin
    cmd_nx = {cmd_sh[CMD_BITS-2:0], din_lvl};
    dat_nx = {dat_sh[DATA_W-2:0], din_lvl};
    op_nx  = cmd_nx[CMD_BITS-1 -: 2];
    sub_nx = cmd_nx[ADDR_W-1 -: 2];
  end

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W)) i_timer (
    .clk(clk), .rst(rst), .go(go), .bulk(bulk),
    .done(done), .wr_en(we), .wr_idx(wr_idx)
  );

  assign waddr = bulk ? wr_idx : tgt_addr;

  nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(pat),
    .raddr(cur_addr), .rdata(q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wel      <= 1'b0;
      bulk     <= 1'b0;
      go       <= 1'b0;
      bcnt     <= '0;
      cmd_sh   <= '0;
      dat_sh   <= '0;
      pat      <= '0;
      tgt_addr <= '0;
      cur_addr <= '0;
      rsh      <= '0;
      rbit     <= '0;
      rd_bit   <= 1'b0;
    end else begin
      go <= 1'b0;
      if (done) begin
        state <= ST_STAT;
      end else if (cs_fall) begin
        if (state == ST_ARM) begin
          state <= ST_PROG;
          go    <= 1'b1;
        end else if (state != ST_PROG) begin
          state <= ST_IDLE;
        end
      end else if (sclk_rise && cs_lvl) begin
        case (state)
          ST_IDLE, ST_STAT: begin
            if (din_lvl) begin
              state <= ST_CMD;
              bcnt  <= '0;
            end
          end
          ST_CMD: begin
            cmd_sh <= cmd_nx;
            bcnt   <= bcnt + 1'b1;
            if (bcnt == CMD_LAST) begin
              bcnt     <= '0;
              tgt_addr <= cmd_nx[ADDR_W-1:0];
              case (op_nx)
                OP_READ: begin
                  state    <= ST_READ;
                  cur_addr <= cmd_nx[ADDR_W-1:0];
                  rbit     <= '0;
                  rd_bit   <= 1'b0;
                end
                OP_WRITE: begin
                  bulk  <= 1'b0;
                  state <= ST_DATA;
                end
                OP_ERASE: begin
                  bulk  <= 1'b0;
                  pat   <= '1;
                  state <= wel ? ST_ARM : ST_SKIP;
                end
                default: begin
                  case (sub_nx)
                    SUB_UNLOCK: begin wel <= 1'b1; state <= ST_SKIP; end
                    SUB_LOCK:   begin wel <= 1'b0; state <= ST_SKIP; end
                    SUB_CLEAR: begin
                      bulk  <= 1'b1;
                      pat   <= '1;
                      state <= wel ? ST_ARM : ST_SKIP;
                    end
                    default: begin
                      bulk  <= 1'b1;
                      state <= ST_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dat_sh <= dat_nx;
            bcnt   <= bcnt + 1'b1;
            if (bcnt == DATA_LAST) begin
              pat   <= dat_nx;
              state <= wel ? ST_ARM : ST_SKIP;
            end
          end
          ST_READ: begin
            if (rbit == RB_LAST) begin
              rd_bit   <= 1'b0;
              rbit     <= '0;
              cur_addr <= cur_addr + 1'b1;
            end else if (rbit == '0) begin
              rd_bit <= q[DATA_W-1];
              rsh    <= {q[DATA_W-2:0], 1'b0};
              rbit   <= rbit + 1'b1;
            end else begin
              rd_bit <= rsh[DATA_W-1];
              rsh    <= {rsh[DATA_W-2:0], 1'b0};
              rbit   <= rbit + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
    end else begin
      sdo_en_q <= cs_lvl && (state inside {ST_READ, ST_PROG, ST_STAT});
      sdo_q    <= (state == ST_READ) ? rd_bit : (state == ST_STAT);
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = sdo_en_q;

  // R7
  prog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> wel);

  // R13
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> !sdo_en_q);

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && $past(state) == ST_READ && cur_addr != $past(cur_addr))
      |-> (cur_addr == $past(cur_addr) + 1'b1));

  // R12
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && !done) |=> (state == ST_PROG));

  // R6
  wel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |=> $stable(wel));
endmodule

// File: tb/test_serial_nvm_slave.sv
module test_serial_nvm_slave;
  localparam int PC = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic sdo, sdo_en;
  int total = 0, bad = 0;
  logic [7:0] rbuf [4];
  int dummy_bad;

  always #10 clk = ~clk;

  serial_nvm_slave #(.PROG_CYCLES(PC)) i_serial_nvm_slave (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .din_i(din),
    .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  // table: {address, data}
  localparam logic [14:0] VEC [6] = '{
    {7'h00, 8'hA5}, {7'h01, 8'h3C}, {7'h7E, 8'h81},
    {7'h7F, 8'hE7}, {7'h40, 8'h00}, {7'h15, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    din = b;
    idle(8);
    s = sdo;
    sclk = 1'b1;
    idle(8);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [1:0] op, input logic [6:0] a,
                      input logic [7:0] d, input bit wd);
    logic s;
    bit_io(1'b1, s);
    for (int i = 1; i >= 0; i--) bit_io(op[i], s);
    for (int i = 6; i >= 0; i--) bit_io(a[i], s);
    if (wd) for (int i = 7; i >= 0; i--) bit_io(d[i], s);
  endtask

  task automatic cs_up();
    cs = 1'b1;
    idle(4);
  endtask

  task automatic cs_down();
    idle(4);
    cs = 1'b0;
    idle(8);
  endtask

  task automatic poll_ready(inout int n);
    while (!(sdo_en === 1'b1 && sdo === 1'b1) && n < 3 * PC) begin
      idle(1);
      n++;
    end
  endtask

  task automatic do_prog(input logic [1:0] op, input logic [6:0] a,
                         input logic [7:0] d, input bit wd,
                         output int n, output bit busy_seen);
    cs_up();
    send(op, a, d, wd);
    idle(4);
    cs = 1'b0;
    n = 0;
    idle(8); n += 8;
    cs = 1'b1;
    idle(6); n += 6;
    busy_seen = (sdo_en === 1'b1 && sdo === 1'b0);
    poll_ready(n);
    cs_down();
  endtask

  task automatic read_seq(input logic [6:0] a, input int cnt, input int lead0);
    logic s;
    cs_up();
    for (int i = 0; i < lead0; i++) bit_io(1'b0, s);
    send(2'b10, a, 8'h00, 1'b0);
    dummy_bad = 0;
    for (int w = 0; w < cnt; w++) begin
      bit_io(1'b0, s);
      if (s !== 1'b0) dummy_bad++;
      for (int b = 7; b >= 0; b--) begin
        bit_io(1'b0, s);
        rbuf[w][b] = s;
      end
    end
    cs_down();
  endtask

  initial begin
    int n;
    bit busy;
    idle(5);
    rst = 1'b0;
    idle(5);

    // R1 / R13: reset state, not driving
    chk("R1 reset sdo_en", sdo_en, 0);
    // R1: latch clear after reset, erase-all gives no busy
    do_prog(2'b00, 7'h40, 8'h00, 1'b0, n, busy);
    chk("R1 no busy before enable", busy, 0);

    // R6: enable
    do_prog(2'b00, 7'h60, 8'h00, 1'b0, n, busy);

    // R8 / R3: vector table write then read-back
    for (int i = 0; i < 6; i++) begin
      do_prog(2'b01, VEC[i][14:8], VEC[i][7:0], 1'b1, n, busy);
      read_seq(VEC[i][14:8], 1, 0);
      chk("R8 write readback", rbuf[0], VEC[i][7:0]);
      chk("R3 dummy bit zero", dummy_bad, 0);
    end

    // R8: overwrite flips bits both ways
    do_prog(2'b01, 7'h01, 8'hC3, 1'b1, n, busy);
    read_seq(7'h01, 1, 0);
    chk("R8 overwrite", rbuf[0], 8'hC3);

    // R4: sequential read with wrap
    read_seq(7'h7E, 3, 0);
    chk("R4 seq word0", rbuf[0], 8'h81);
    chk("R4 seq word1", rbuf[1], 8'hE7);
    chk("R4 wrap word2", rbuf[2], 8'hA5);
    chk("R3 dummies in stream", dummy_bad, 0);

    // R9 / R11: erase, busy and cycle length
    do_prog(2'b11, 7'h7F, 8'h00, 1'b0, n, busy);
    chk("R11 busy low", busy, 1);
    chk("R11 cycle length", (n >= PC - 10 && n <= PC + 12), 1);
    read_seq(7'h7F, 1, 0);
    chk("R9 erase", rbuf[0], 8'hFF);

    // R12: traffic during busy ignored
    cs_up();
    send(2'b01, 7'h00, 8'h11, 1'b1);
    idle(4);
    cs = 1'b0;
    idle(8);
    cs = 1'b1;
    send(2'b01, 7'h00, 8'h22, 1'b1);
    n = 0;
    poll_ready(n);
    cs_down();
    read_seq(7'h00, 1, 0);
    chk("R12 busy traffic ignored", rbuf[0], 8'h11);

    // R6 / R7 / R5: disable, then modifying instructions do nothing
    do_prog(2'b00, 7'h00, 8'h00, 1'b0, n, busy);
    do_prog(2'b01, 7'h00, 8'h99, 1'b1, n, busy);
    chk("R7 write no busy", busy, 0);
    do_prog(2'b11, 7'h15, 8'h00, 1'b0, n, busy);
    chk("R7 erase no busy", busy, 0);
    read_seq(7'h00, 1, 0);
    chk("R5 read while disabled", rbuf[0], 8'h11);
    read_seq(7'h40, 1, 0);
    chk("R7 array unchanged", rbuf[0], 8'h00);

    // R10: write-all then erase-all
    do_prog(2'b00, 7'h60, 8'h00, 1'b0, n, busy);
    do_prog(2'b00, 7'h20, 8'h5A, 1'b1, n, busy);
    chk("R10 write-all busy", busy, 1);
    read_seq(7'h7F, 2, 0);
    chk("R10 write-all 7F", rbuf[0], 8'h5A);
    chk("R10 write-all 00", rbuf[1], 8'h5A);
    // R2: leading zeros before start bit
    read_seq(7'h40, 1, 3);
    chk("R2 leading zeros", rbuf[0], 8'h5A);
    do_prog(2'b00, 7'h40, 8'h00, 1'b0, n, busy);
    read_seq(7'h01, 1, 0);
    chk("R10 erase-all 01", rbuf[0], 8'hFF);
    read_seq(7'h7E, 1, 0);
    chk("R10 erase-all 7E", rbuf[0], 8'hFF);

    // R13: not driven with chip select low
    idle(4);
    chk("R13 hiz cs low", sdo_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule